// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and reports whether the first is greater than, equal to, or less than the second, using three mutually exclusive flags. It is purely combinational. Internally it is a chain of 4-bit slices. Each slice examines its own bit pairs from the most significant position downward. The first position where the operands differ settles that slice's verdict.

When every bit pair in a slice matches, the slice passes on the verdict it receives from the slice below it. The lowest slice takes its incoming verdict from three cascade inputs on the top module. The top module can therefore act as one stage of a still wider chain. For a stand-alone comparison, the cascade inputs are driven as "equal".

Top module: `mag_cmp_chain`

## Requirements
- R1: When the cascade inputs carry exactly one high line, exactly one of aGreater, aEqual, aLess is high.
- R2: If opA > opB as unsigned numbers, aGreater=1 and aEqual=aLess=0, whatever the cascade inputs are.
- R3: If opA < opB as unsigned numbers, aLess=1 and aGreater=aEqual=0, whatever the cascade inputs are.
- R4: If opA == opB, the outputs (aGreater, aEqual, aLess) equal the cascade inputs (cascGtIn, cascEqIn, cascLtIn).
- R5: The result is decided by the highest bit position where opA and opB differ, and all lower bits are ignored. For example, 0x80 against 0x7F gives aGreater.
- R6: The operand width is 4 × NUM_SLICES. A difference that lies only in the lowest 4-bit slice still determines the output when all higher slices tie.
- R7: With cascEqIn=1 and cascGtIn=cascLtIn=0, the outputs equal the unsigned relations opA>opB, opA==opB and opA<opB.
- R8: A cascade pattern that is not one-hot, such as gt=1 and lt=1, or all zero, reaches the outputs unchanged when opA == opB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4*NUM_SLICES | First operand, unsigned |
| opB | input | 4*NUM_SLICES | Second operand, unsigned |
| cascGtIn | input | 1 | Verdict "greater" from a lower-order stage |
| cascEqIn | input | 1 | Verdict "equal" from a lower-order stage |
| cascLtIn | input | 1 | Verdict "less" from a lower-order stage |
| aGreater | output | 1 | opA greater than opB |
| aEqual | output | 1 | opA equal to opB |
| aLess | output | 1 | opA less than opB |

## Verification
A single-slice instance is driven through every operand pair, once with each legal cascade value. This exposes any error in the per-bit priority and in the forwarding of ties. The two-slice default instance is swept over all operand pairs with the cascade tied to "equal". This separates a broken link between slices from a broken slice.

Directed vectors cover several targeted cases:
- Operands that differ only in the most significant bit, with the lower bits inverted, to show that lower bits are ignored.
- Differences confined to the lowest slice.
- Cascade values that disagree with the local result, which the local result must override.
- Non-one-hot cascade patterns, which must be forwarded unchanged.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
  // Three-way verdict carried between slices.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;
endpackage

// File: rtl/cmp_bit_match.sv
// Per-bit datapath: equality (XNOR) and which side holds a one.
module cmp_bit_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] match,
  output logic [W-1:0] aHigh,
  output logic [W-1:0] bHigh
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign match[i] = ~(a[i] ^ b[i]);
    assign aHigh[i] = a[i] & ~b[i];
    assign bHigh[i] = ~a[i] & b[i];
  end
endmodule

// File: rtl/cmp_resolve.sv
// Priority scan from the top bit down; a full tie defers to cascIn.
module cmp_resolve
  import magcmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] match,
  input  logic [W-1:0] aHigh,
  input  logic [W-1:0] bHigh,
  input  verdict_t     cascIn,
  output verdict_t     verdictOut
);
  logic tieAbove;
  logic gtLocal;
  logic ltLocal;

  always_comb begin
    tieAbove = 1'b1;
    gtLocal  = 1'b0;
    ltLocal  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      gtLocal  = gtLocal | (tieAbove & aHigh[i]);
      ltLocal  = ltLocal | (tieAbove & bHigh[i]);
      tieAbove = tieAbove & match[i];
    end
    verdictOut.gt = gtLocal | (tieAbove & cascIn.gt);
    verdictOut.eq = tieAbove & cascIn.eq;
    verdictOut.lt = ltLocal | (tieAbove & cascIn.lt);
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import magcmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  verdict_t     cascIn,
  output verdict_t     verdictOut
);
  logic [W-1:0] match;
  logic [W-1:0] aHigh;
  logic [W-1:0] bHigh;

  cmp_bit_match #(.W(W)) u_match (
    .a(a), .b(b), .match(match), .aHigh(aHigh), .bHigh(bHigh)
  );

  cmp_resolve #(.W(W)) u_resolve (
    .match(match), .aHigh(aHigh), .bHigh(bHigh),
    .cascIn(cascIn), .verdictOut(verdictOut)
  );
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import magcmp_pkg::*;
#(
  parameter int NUM_SLICES = 2,
  parameter int SLICE_W    = 4,
  localparam int DATA_W    = NUM_SLICES * SLICE_W
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              cascGtIn,
  input  logic              cascEqIn,
  input  logic              cascLtIn,
  output logic              aGreater,
  output logic              aEqual,
  output logic              aLess
);
  // link[k] enters slice k; link[NUM_SLICES] is the final verdict.
  verdict_t link [NUM_SLICES+1];

  assign link[0] = '{gt: cascGtIn, eq: cascEqIn, lt: cascLtIn};

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cmp_slice #(.W(SLICE_W)) u_slice (
      .a(opA[k*SLICE_W +: SLICE_W]),
      .b(opB[k*SLICE_W +: SLICE_W]),
      .cascIn(link[k]),
      .verdictOut(link[k+1])
    );
  end

  assign aGreater = link[NUM_SLICES].gt;
  assign aEqual   = link[NUM_SLICES].eq;
  assign aLess    = link[NUM_SLICES].lt;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              cascGtIn,
  input logic              cascEqIn,
  input logic              cascLtIn,
  input logic              aGreater,
  input logic              aEqual,
  input logic              aLess
);
  always_comb begin
    // R1
    if ($onehot({cascGtIn, cascEqIn, cascLtIn}))
      a_r1_onehot: assert ($onehot({aGreater, aEqual, aLess}))
        else $error("R1 outputs not one-hot");
    // R2
    if (opA > opB)
      a_r2_greater: assert ({aGreater, aEqual, aLess} == 3'b100)
        else $error("R2 greater verdict wrong");
    // R3
    if (opA < opB)
      a_r3_less: assert ({aGreater, aEqual, aLess} == 3'b001)
        else $error("R3 less verdict wrong");
    // R4 / R8
    if (opA == opB)
      a_r4_forward: assert ({aGreater, aEqual, aLess} == {cascGtIn, cascEqIn, cascLtIn})
        else $error("R4 tie did not forward cascade");
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.DATA_W(NUM_SLICES * SLICE_W)) u_chk (
  .opA(opA), .opB(opB),
  .cascGtIn(cascGtIn), .cascEqIn(cascEqIn), .cascLtIn(cascLtIn),
  .aGreater(aGreater), .aEqual(aEqual), .aLess(aLess)
);

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;
  localparam int W8 = 8;
  localparam int W4 = 4;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [W8-1:0] a8, b8;
  logic [2:0]    c8;
  logic          g8, e8, l8;
  logic [W4-1:0] a4, b4;
  logic [2:0]    c4;
  logic          g4, e4, l4;

  mag_cmp_chain u_mag_cmp_chain (
    .opA(a8), .opB(b8),
    .cascGtIn(c8[2]), .cascEqIn(c8[1]), .cascLtIn(c8[0]),
    .aGreater(g8), .aEqual(e8), .aLess(l8)
  );

  mag_cmp_chain #(.NUM_SLICES(1)) u_mag_cmp_chain_one (
    .opA(a4), .opB(b4),
    .cascGtIn(c4[2]), .cascEqIn(c4[1]), .cascLtIn(c4[0]),
    .aGreater(g4), .aEqual(e4), .aLess(l4)
  );

  // {opA, opB, cascade{gt,eq,lt}, expected{gt,eq,lt}}
  localparam logic [21:0] VECS [NVEC] = '{
    {8'h00, 8'h00, 3'b010, 3'b010},  // R4 all-zero start state
    {8'h80, 8'h7F, 3'b010, 3'b100},  // R5 top bit decides
    {8'h7F, 8'h80, 3'b010, 3'b001},  // R5
    {8'h01, 8'h00, 3'b010, 3'b100},  // R6 lowest slice decides
    {8'h10, 8'h1F, 3'b010, 3'b001},  // R6 upper tie, lower less
    {8'hA5, 8'hA5, 3'b100, 3'b100},  // R4
    {8'hA5, 8'hA5, 3'b001, 3'b001},  // R4
    {8'h60, 8'h50, 3'b001, 3'b100},  // R2 local beats cascade
    {8'h05, 8'h06, 3'b100, 3'b001},  // R3 local beats cascade
    {8'h33, 8'h33, 3'b101, 3'b101},  // R8 gt and lt both high
    {8'hFF, 8'hFF, 3'b000, 3'b000},  // R8 all low
    {8'hFF, 8'hFE, 3'b010, 3'b100}   // R7
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a8=%h b8=%h a4=%h b4=%h actual=%b expected=%b",
               req, a8, b8, a4, b4, act, exp);
    end
  endtask

  function automatic logic [2:0] relate(input int x, input int y, input logic [2:0] c);
    if (x > y) return 3'b100;
    if (x < y) return 3'b001;
    return c;
  endfunction

  initial begin
    a8 = '0; b8 = '0; c8 = 3'b010;
    a4 = '0; b4 = '0; c4 = 3'b010;
    @(negedge clk);

    // Directed table
    for (int v = 0; v < NVEC; v++) begin
      a8 = VECS[v][21:14];
      b8 = VECS[v][13:6];
      c8 = VECS[v][5:3];
      #2;
      check("R2/R3/R4/R5/R6/R8 table", {g8, e8, l8}, VECS[v][2:0]);
    end

    // R1 R2 R3 R4: exhaustive single slice, each legal cascade value
    for (int c = 0; c < 3; c++) begin
      c4 = 3'b001 << c;
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          a4 = x[3:0];
          b4 = y[3:0];
          #1;
          check("R1", 3'($countones({g4, e4, l4})), 3'd1);
          check("R2/R3/R4 slice", {g4, e4, l4}, relate(x, y, c4));
        end
      end
    end

    // R7 R6: exhaustive two-slice chain with cascade tied to equal
    c8 = 3'b010;
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        a8 = x[7:0];
        b8 = y[7:0];
        #1;
        check("R7 chain", {g8, e8, l8}, relate(x, y, 3'b010));
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule